// File: doc/BRIEF.md
# Convolution Output Scaling and Activation Stage

This stage sits at the end of one output channel of a convolution engine. It accepts the full-resolution signed sum-of-products for a channel, together with that channel's bias and per-beat configuration, and produces the value that is written back as the layer's result. The arithmetic runs in a fixed order: bias addition, a programmable arithmetic shift that can go left or right, an activation function, and a final format step that yields either an 8-bit value (sign-extended onto the output bus) or a full 32-bit value for a network's last layer.

A pass-through option skips all arithmetic and forwards the accumulator input unchanged, which is used when data only has to be moved. Beats enter and leave through valid/ready handshakes. The pipeline is three registers deep and holds its contents when the consumer is not ready. Configuration travels with each beat, so consecutive beats may use different settings.

Top module: `cnn_out_stage`

## Requirements
- R1: The bias is a signed value taken from `inBias[7:0]` when `cfgWideBias` is 0, and from all ten bits of `inBias` when it is 1. It is sign-extended and added to `inAcc` exactly, with no overflow at this step.
- R2: With `cfgShiftUp` = 1, the biased sum is shifted left by `cfgShiftAmt` (0..15) bits. The result saturates to 0x7FFFFFFF or 0x80000000 when it leaves the signed 32-bit range. A biased sum that exceeds that range with a shift of 0 saturates the same way.
- R3: With `cfgShiftUp` = 0, the biased sum is shifted right arithmetically by `cfgShiftAmt` bits, rounding toward negative infinity. For example, -5 shifted by 1 gives -3, and -1 shifted by 15 stays -1.
- R4: `cfgAct` encodes the activation: 0 = none, 1 = ReLU (negative values become 0), 2 = absolute value, and 3 behaves as none. The absolute value of -2^31 is 0x7FFFFFFF.
- R5: With `cfgOut32` = 0, the activated value is clamped to -128..127 and sign-extended to 32 bits on `outData`. The absolute value of -128 therefore becomes 127.
- R6: With `cfgOut32` = 1, the activated 32-bit value is output without clamping.
- R7: With `cfgPass` = 1, `outData` equals the beat's `inAcc` bit for bit, whatever the other configuration inputs are.
- R8: If `outReady` is held high, a beat accepted on a rising edge is presented on `outValid`/`outData` after the second rising edge that follows the accepting edge.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values. `inReady` is 1 exactly when `outValid` is 0 or `outReady` is 1.
- R10: After reset, `outValid` is 0 and `inReady` is 1.
- R11: Every accepted beat is output exactly once, in the order in which the beats were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat is offered |
| inReady | output | 1 | Stage can take a beat |
| inAcc | input | 32 | Signed accumulator, or raw data in pass-through |
| inBias | input | 10 | Signed bias; only the low 8 bits are used in narrow mode |
| cfgWideBias | input | 1 | Selects the 10-bit bias |
| cfgShiftUp | input | 1 | 1 = shift left, 0 = shift right |
| cfgShiftAmt | input | 4 | Shift distance, 0 to 15 |
| cfgAct | input | 2 | Activation select |
| cfgOut32 | input | 1 | 1 = 32-bit output, 0 = clamped 8-bit |
| cfgPass | input | 1 | Forward inAcc unchanged |
| outValid | output | 1 | Output beat is present |
| outReady | input | 1 | Consumer takes the beat |
| outData | output | 32 | Result |

## Verification
Directed beats drive the main arithmetic with:
- small values that only the bias sign-extension width can tell apart;
- sums placed next to the 32-bit limits, so that saturation after a left shift is separated from plain wrap-around;
- negative odd values shifted right, which separates flooring from truncation toward zero;
- the values -128 and -2^31 under the absolute-value activation.

A random phase with randomly withheld `outReady` then mixes all settings beat by beat. In that phase a behavioural reference and queue check the order and the values of the results, and check that the output holds during stalls.

// File: rtl/cnn_out_pkg.sv
package cnn_out_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_RELU = 2'd1,
    ACT_ABS  = 2'd2,
    ACT_RSVD = 2'd3
  } act_e;

  // Per-stage load strobes from control to datapath
  typedef struct packed {
    logic load1;
    logic load2;
    logic load3;
  } pipe_strb_t;

endpackage

// File: rtl/cnn_out_ctrl.sv
module cnn_out_ctrl
  import cnn_out_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output pipe_strb_t strb
);

  logic v1, v2, v3;
  logic advance;

  // Whole pipe moves when the last slot is empty or being drained
  assign advance  = !v3 || outReady;
  assign inReady  = advance;
  assign outValid = v3;

  always_comb begin
    strb.load1 = advance && inValid;
    strb.load2 = advance && v1;
    strb.load3 = advance && v2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (advance) begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

endmodule

// File: rtl/cnn_out_dp.sv
module cnn_out_dp
  import cnn_out_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int BIAS_W  = 10,
  parameter int NBIAS_W = 8,
  parameter int SHIFT_W = 4,
  parameter int NOUT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pipe_strb_t         strb,
  input  logic [ACC_W-1:0]   inAcc,
  input  logic [BIAS_W-1:0]  inBias,
  input  logic               cfgWideBias,
  input  logic               cfgShiftUp,
  input  logic [SHIFT_W-1:0] cfgShiftAmt,
  input  logic [1:0]         cfgAct,
  input  logic               cfgOut32,
  input  logic               cfgPass,
  output logic [ACC_W-1:0]   outData
);

  localparam int SUM_W  = ACC_W + 1;
  localparam int MAX_SH = (1 << SHIFT_W) - 1;
  localparam int WIDE_W = SUM_W + MAX_SH;

  localparam logic signed [WIDE_W-1:0] WIDE_MAX = {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] WIDE_MIN = {{(WIDE_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0]  ACC_MAX  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  ACC_MIN  = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0]  NAR_MAX  = {{(ACC_W-NOUT_W+1){1'b0}}, {(NOUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  NAR_MIN  = {{(ACC_W-NOUT_W+1){1'b1}}, {(NOUT_W-1){1'b0}}};

  // Stage 1: bias add (or raw capture for pass-through)
  logic signed [SUM_W-1:0] biasExt, sumNext;
  logic signed [SUM_W-1:0] s1Sum;
  logic                    s1Up, s1Out32, s1Pass;
  logic [SHIFT_W-1:0]      s1Amt;
  act_e                    s1Act;

  always_comb begin
    if (cfgWideBias)
      biasExt = {{(SUM_W-BIAS_W){inBias[BIAS_W-1]}}, inBias};
    else
      biasExt = {{(SUM_W-NBIAS_W){inBias[NBIAS_W-1]}}, inBias[NBIAS_W-1:0]};
    if (cfgPass)
      sumNext = {1'b0, inAcc};
    else
      sumNext = $signed({inAcc[ACC_W-1], inAcc}) + biasExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sum   <= '0;
      s1Up    <= 1'b0;
      s1Amt   <= '0;
      s1Act   <= ACT_NONE;
      s1Out32 <= 1'b0;
      s1Pass  <= 1'b0;
    end else if (strb.load1) begin
      s1Sum   <= sumNext;
      s1Up    <= cfgShiftUp;
      s1Amt   <= cfgShiftAmt;
      s1Act   <= act_e'(cfgAct);
      s1Out32 <= cfgOut32;
      s1Pass  <= cfgPass;
    end
  end

  // Stage 2: bidirectional shift with 32-bit saturation
  logic signed [WIDE_W-1:0] wideIn, wideShift;
  logic signed [ACC_W-1:0]  shiftNext;
  logic signed [ACC_W-1:0]  s2Val;
  logic                     s2Out32, s2Pass;
  act_e                     s2Act;

  always_comb begin
    wideIn = {{(WIDE_W-SUM_W){s1Sum[SUM_W-1]}}, s1Sum};
    if (s1Up)
      wideShift = wideIn <<< s1Amt;
    else
      wideShift = wideIn >>> s1Amt;
    if (s1Pass)
      shiftNext = s1Sum[ACC_W-1:0];
    else if (wideShift > WIDE_MAX)
      shiftNext = ACC_MAX;
    else if (wideShift < WIDE_MIN)
      shiftNext = ACC_MIN;
    else
      shiftNext = wideShift[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Val   <= '0;
      s2Act   <= ACT_NONE;
      s2Out32 <= 1'b0;
      s2Pass  <= 1'b0;
    end else if (strb.load2) begin
      s2Val   <= shiftNext;
      s2Act   <= s1Act;
      s2Out32 <= s1Out32;
      s2Pass  <= s1Pass;
    end
  end

  // Stage 3: activation and output format
  logic signed [ACC_W-1:0] actVal, fmtVal;

  always_comb begin
    unique case (s2Act)
      ACT_RELU: actVal = s2Val[ACC_W-1] ? '0 : s2Val;
      ACT_ABS: begin
        if (s2Val == ACC_MIN)     actVal = ACC_MAX;
        else if (s2Val[ACC_W-1])  actVal = -s2Val;
        else                      actVal = s2Val;
      end
      default: actVal = s2Val;
    endcase
    if (s2Pass || s2Out32)    fmtVal = s2Pass ? s2Val : actVal;
    else if (actVal > NAR_MAX) fmtVal = NAR_MAX;
    else if (actVal < NAR_MIN) fmtVal = NAR_MIN;
    else                       fmtVal = actVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outData <= '0;
    else if (strb.load3) outData <= fmtVal;
  end

endmodule

// File: rtl/cnn_out_stage.sv
module cnn_out_stage
  import cnn_out_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int BIAS_W  = 10,
  parameter int NBIAS_W = 8,
  parameter int SHIFT_W = 4,
  parameter int NOUT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ACC_W-1:0]   inAcc,
  input  logic [BIAS_W-1:0]  inBias,
  input  logic               cfgWideBias,
  input  logic               cfgShiftUp,
  input  logic [SHIFT_W-1:0] cfgShiftAmt,
  input  logic [1:0]         cfgAct,
  input  logic               cfgOut32,
  input  logic               cfgPass,
  output logic               outValid,
  input  logic               outReady,
  output logic [ACC_W-1:0]   outData
);

  pipe_strb_t strb;

  cnn_out_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strb     (strb)
  );

  cnn_out_dp #(
    .ACC_W   (ACC_W),
    .BIAS_W  (BIAS_W),
    .NBIAS_W (NBIAS_W),
    .SHIFT_W (SHIFT_W),
    .NOUT_W  (NOUT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inAcc       (inAcc),
    .inBias      (inBias),
    .cfgWideBias (cfgWideBias),
    .cfgShiftUp  (cfgShiftUp),
    .cfgShiftAmt (cfgShiftAmt),
    .cfgAct      (cfgAct),
    .cfgOut32    (cfgOut32),
    .cfgPass     (cfgPass),
    .outData     (outData)
  );

endmodule

// File: rtl/cnn_out_chk.sv
module cnn_out_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [ACC_W-1:0] outData
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R9

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid || outReady) |-> inReady); // R9

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 outReady ##1 outReady |=> outValid); // R8

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady)); // R11

endmodule

bind cnn_out_stage cnn_out_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/cnn_out_stage_bench.sv
`timescale 1ns/1ps
module cnn_out_stage_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inAcc = '0;
  logic [9:0]  inBias = '0;
  logic        cfgWideBias = 1'b0;
  logic        cfgShiftUp = 1'b0;
  logic [3:0]  cfgShiftAmt = '0;
  logic [1:0]  cfgAct = '0;
  logic        cfgOut32 = 1'b0;
  logic        cfgPass = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;

  int    errors = 0;
  int    checks = 0;
  bit    readyRandom = 1'b0;
  string curTag = "R11";

  logic [31:0] expQ[$];
  string       tagQ[$];
  bit          holdPrev = 1'b0;
  logic [31:0] prevData;

  always #2.5 clk = ~clk;

  cnn_out_stage u_cnn_out_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAcc(inAcc), .inBias(inBias), .cfgWideBias(cfgWideBias),
    .cfgShiftUp(cfgShiftUp), .cfgShiftAmt(cfgShiftAmt), .cfgAct(cfgAct),
    .cfgOut32(cfgOut32), .cfgPass(cfgPass), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  function automatic longint clampRange(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Behavioural reference from the requirements
  function automatic logic [31:0] refModel(logic [31:0] acc, logic [9:0] bias,
      bit wide, bit up, int amt, int act, bit o32, bit pass);
    longint b, v;
    if (pass) return acc;
    b = wide ? longint'($signed(bias)) : longint'($signed(bias[7:0]));
    v = longint'($signed(acc)) + b;
    if (up) v = v * (longint'(1) << amt);
    else    v = v >>> amt;
    v = clampRange(v, -64'sd2147483648, 64'sd2147483647);
    if (act == 1 && v < 0) v = 0;
    if (act == 2 && v < 0) v = clampRange(-v, -64'sd2147483648, 64'sd2147483647);
    if (!o32) v = clampRange(v, -128, 127);
    return v[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // outReady driver
  always @(negedge clk) outReady = readyRandom ? (($urandom % 3) != 0) : 1'b1;

  // Scoreboard, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (holdPrev) begin
        check("R9 valid hold", {31'd0, outValid}, 32'd1);
        check("R9 data hold", outData, prevData);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) check("R11 extra output", 32'd1, 32'd0);
        else check(tagQ.pop_front(), outData, expQ.pop_front());
      end
      if (inValid && inReady) begin
        expQ.push_back(refModel(inAcc, inBias, cfgWideBias, cfgShiftUp,
                                int'(cfgShiftAmt), int'(cfgAct), cfgOut32, cfgPass));
        tagQ.push_back(curTag);
      end
      holdPrev = outValid && !outReady;
      prevData = outData;
    end
  end

  task automatic send(string tag, logic [31:0] acc, logic [9:0] bias, bit wide,
      bit up, logic [3:0] amt, logic [1:0] act, bit o32, bit pass);
    @(negedge clk);
    curTag = tag; inAcc = acc; inBias = bias; cfgWideBias = wide;
    cfgShiftUp = up; cfgShiftAmt = amt; cfgAct = act; cfgOut32 = o32;
    cfgPass = pass; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R10 outValid", {31'd0, outValid}, 32'd0);
    check("R10 inReady", {31'd0, inReady}, 32'd1);

    // R8 latency with outReady high
    send("R8", 32'd40, 10'd2, 0, 0, 4'd1, 2'd0, 1, 0);
    @(negedge clk); inValid = 1'b0; #1;
    check("R8 after accept edge", {31'd0, outValid}, 32'd0);
    @(negedge clk); #1;
    check("R8 after one more edge", {31'd0, outValid}, 32'd0);
    @(negedge clk); #1;
    check("R8 after second edge", {31'd0, outValid}, 32'd1);

    // R1 bias widths
    send("R1", 32'd100, 10'h3FF, 0, 0, 4'd0, 2'd0, 1, 0);
    send("R1", 32'd100, 10'h27F, 0, 0, 4'd0, 2'd0, 1, 0);
    send("R1", 32'd100, 10'h200, 1, 0, 4'd0, 2'd0, 1, 0);
    send("R1", 32'd100, 10'h17F, 1, 0, 4'd0, 2'd0, 1, 0);
    // R2 left shift and saturation
    send("R2", 32'd3, 10'd0, 0, 1, 4'd4, 2'd0, 1, 0);
    send("R2", 32'h4000_0000, 10'd0, 0, 1, 4'd1, 2'd0, 1, 0);
    send("R2", 32'hC000_0000, 10'd0, 0, 1, 4'd2, 2'd0, 1, 0);
    send("R2", 32'h7FFF_FFFF, 10'h07F, 0, 0, 4'd0, 2'd0, 1, 0);
    send("R2", 32'h8000_0000, 10'h080, 0, 1, 4'd0, 2'd0, 1, 0);
    send("R2", 32'hFFFF_FFFF, 10'd0, 0, 1, 4'd15, 2'd0, 1, 0);
    // R3 right shift flooring
    send("R3", 32'hFFFF_FFFB, 10'd0, 0, 0, 4'd1, 2'd0, 1, 0);
    send("R3", 32'hFFFF_FFFF, 10'd0, 0, 0, 4'd15, 2'd0, 1, 0);
    send("R3", 32'd1000, 10'd0, 0, 0, 4'd3, 2'd0, 1, 0);
    // R4 activations
    send("R4", 32'hFFFF_FFF9, 10'd0, 0, 0, 4'd0, 2'd1, 1, 0);
    send("R4", 32'hFFFF_FFF9, 10'd0, 0, 0, 4'd0, 2'd2, 1, 0);
    send("R4", 32'h8000_0000, 10'd0, 0, 0, 4'd0, 2'd2, 1, 0);
    send("R4", 32'hFFFF_FFF9, 10'd0, 0, 0, 4'd0, 2'd3, 1, 0);
    send("R4", 32'd9, 10'd0, 0, 0, 4'd0, 2'd1, 1, 0);
    // R5 narrow format
    send("R5", 32'd300, 10'd0, 0, 0, 4'd0, 2'd0, 0, 0);
    send("R5", 32'hFFFF_FED4, 10'd0, 0, 0, 4'd0, 2'd0, 0, 0);
    send("R5", 32'hFFFF_FF80, 10'd0, 0, 0, 4'd0, 2'd2, 0, 0);
    send("R5", 32'hFFFF_FFC9, 10'd0, 0, 0, 4'd0, 2'd0, 0, 0);
    // R6 wide format
    send("R6", 32'd300, 10'd0, 0, 0, 4'd0, 2'd0, 1, 0);
    // R7 pass-through with odd settings
    send("R7", 32'h8000_1234, 10'h155, 1, 1, 4'd9, 2'd2, 0, 1);
    send("R7", 32'h0000_7FFF, 10'h3FF, 0, 0, 4'd15, 2'd1, 0, 1);
    idle();

    // Random mix with back-pressure
    readyRandom = 1'b1;
    for (int i = 0; i < 400; i++) begin
      send((i % 2) ? "R9" : "R11", $urandom, 10'($urandom), 1'($urandom),
           1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
           (($urandom % 8) == 0));
      if (($urandom % 4) == 0) idle();
    end
    idle();
    readyRandom = 1'b0;
    repeat (20) @(negedge clk);
    check("R11 all drained", 32'(expQ.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule